// File: doc/BRIEF.md
# Single-Clock FIFO with Programmable Flags

This block is a first-in first-out buffer in which writes and reads share one clock. A producer pushes a word by raising the write enable with data on the write bus. A consumer pops a word by raising the read enable, and the word is returned on the read bus. The buffer reports whether it is full or empty. It also reports when it is near either end, where the nearness is set by two parameters. If a push arrives while the buffer is full, or a pop arrives while it is empty, the operation is refused and the block raises an error strobe for one cycle. The write and read pointers are visible on two count outputs.

The storage depth is not a free parameter. It follows from the data width and from a capacity choice, small or large. With the small capacity the depth is 4096 entries for widths 1 to 4, 2048 for widths 5 to 9, 1024 for widths 10 to 18 and 512 for widths 19 to 36. The large capacity doubles each of these depths. Widths 37 to 72 are supported only with the large capacity, at 512 entries. An optional pipeline stage on the read bus improves output timing at the cost of one cycle of read latency. The flags are not delayed by this stage.

Top module: `sfifo_prog`

## Requirements
- R1: While the active-high reset is asserted, and immediately on its assertion without waiting for a clock edge, the block shows: empty 1; full, almostFull, wrErr and rdErr 0; both counts 0; read data 0.
- R2: The depth is derived from width and capacity as described above (512 for the default 36-bit small setting). full is 1 exactly when the occupancy equals the depth, and empty is 1 exactly when the occupancy is 0.
- R3: Words leave in the order they were accepted. With the output stage off, a popped word appears on rdData after the clock edge that accepts the pop. rdData holds its value in every other cycle.
- R4: With the output stage on, rdData shows the same sequence of words one clock later than it would with the stage off.
- R5: almostEmpty is 1 exactly when the occupancy is less than or equal to the almost-empty offset (128 by default).
- R6: almostFull is 1 exactly when the occupancy is greater than or equal to the depth minus the almost-full offset (384 by default at depth 512).
- R7: A write request while full is ignored: the memory, wrCount and occupancy are unchanged. wrErr is 1 for exactly the cycle after that request.
- R8: A read request while empty is ignored: rdCount and rdData are unchanged. rdErr is 1 for exactly the cycle after that request.
- R9: A write and a read in the same cycle leave the occupancy unchanged when the buffer is neither empty nor full. When the buffer is empty, only the write takes effect. When it is full, only the read takes effect, and wrErr still pulses.
- R10: wrCount and rdCount are the write and read pointers, each log2(depth) bits wide. Each pointer advances by one, modulo the depth, on every accepted write or read respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the write and read sides |
| rst | input | 1 | Asynchronous reset, active high |
| wrData | input | DataWidth | Word to store |
| wrEn | input | 1 | Write request |
| rdEn | input | 1 | Read request |
| rdData | output | DataWidth | Word returned by a read |
| full | output | 1 | Occupancy equals depth |
| empty | output | 1 | Occupancy is zero |
| almostFull | output | 1 | Free space within the almost-full offset |
| almostEmpty | output | 1 | Occupancy within the almost-empty offset |
| wrErr | output | 1 | One-cycle strobe after a refused write |
| rdErr | output | 1 | One-cycle strobe after a refused read |
| rdCount | output | log2(depth) | Read pointer |
| wrCount | output | log2(depth) | Write pointer |

## Verification
The bench fills the buffer to exactly its depth and then pushes once more. A design with a wrong depth rule, or an off-by-one full compare, either raises full one word early or silently overwrites the oldest entry, and the returned data sequence then breaks. Simultaneous read and write are driven at empty, at full and in the middle of the range. A design that lets a read win on an empty buffer would return stale data and skew the pointers. The bench sweeps occupancy across both thresholds, where a strict-versus-inclusive compare error shows as a flag one word off. It also asserts reset between clock edges, which exposes a reset that was made synchronous.

// File: rtl/sfifo_pkg.sv
`timescale 1ns/1ps
package sfifo_pkg;

  // Strobes from the control half to the storage half
  typedef struct packed {
    logic wrFire;
    logic rdFire;
  } memStrobe_t;

  // Entry count for a given word width and capacity choice
  function automatic int unsigned depthFor(input int unsigned width, input bit bigCap);
    int unsigned d;
    if (width <= 4)       d = 4096;
    else if (width <= 9)  d = 2048;
    else if (width <= 18) d = 1024;
    else if (width <= 36) d = 512;
    else                  d = 256;   // wide words: only the large capacity is legal
    if (bigCap) d = d * 2;
    return d;
  endfunction

endpackage

// File: rtl/sfifo_ctrl.sv
`timescale 1ns/1ps
module sfifo_ctrl
  import sfifo_pkg::*;
#(
  parameter int unsigned Depth    = 512,
  parameter int unsigned CntW     = 9,
  parameter int unsigned AeOffset = 128,
  parameter int unsigned AfOffset = 128
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wrEn,
  input  logic            rdEn,
  output memStrobe_t      strobe,
  output logic [CntW-1:0] wrPtr,
  output logic [CntW-1:0] rdPtr,
  output logic            full,
  output logic            empty,
  output logic            almostFull,
  output logic            almostEmpty,
  output logic            wrErr,
  output logic            rdErr
);

  localparam int unsigned OccW    = CntW + 1;
  localparam int unsigned AfLevel = (AfOffset >= Depth) ? 0 : Depth - AfOffset;
  localparam int unsigned AeLevel = (AeOffset >= Depth) ? Depth : AeOffset;

  logic [OccW-1:0] occ;
  logic [OccW-1:0] occNext;
  logic            wrFire;
  logic            rdFire;

  // Acceptance: a refused side does not block the other side
  always_comb begin
    wrFire = wrEn && !full;
    rdFire = rdEn && !empty;
    unique case ({wrFire, rdFire})
      2'b10:   occNext = occ + 1'b1;
      2'b01:   occNext = occ - 1'b1;
      default: occNext = occ;
    endcase
  end

  always_comb begin
    strobe.wrFire = wrFire;
    strobe.rdFire = rdFire;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      occ   <= '0;
      wrPtr <= '0;
      rdPtr <= '0;
      wrErr <= 1'b0;
      rdErr <= 1'b0;
    end else begin
      occ   <= occNext;
      if (wrFire) wrPtr <= wrPtr + 1'b1;
      if (rdFire) rdPtr <= rdPtr + 1'b1;
      wrErr <= wrEn && full;
      rdErr <= rdEn && empty;
    end
  end

  // Flags decode the registered occupancy
  assign empty       = (occ == '0);
  assign full        = (occ == OccW'(Depth));
  assign almostEmpty = (occ <= OccW'(AeLevel));
  assign almostFull  = (occ >= OccW'(AfLevel));

endmodule

// File: rtl/sfifo_datapath.sv
`timescale 1ns/1ps
module sfifo_datapath
  import sfifo_pkg::*;
#(
  parameter int unsigned DataW  = 36,
  parameter int unsigned Depth  = 512,
  parameter int unsigned CntW   = 9,
  parameter bit          OutReg = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  memStrobe_t       strobe,
  input  logic [CntW-1:0]  wrPtr,
  input  logic [CntW-1:0]  rdPtr,
  input  logic [DataW-1:0] wrData,
  output logic [DataW-1:0] rdData
);

  logic [DataW-1:0] mem [Depth];
  logic [DataW-1:0] readStage;

  // Storage array, no reset so it maps to plain RAM
  always_ff @(posedge clk) begin
    if (strobe.wrFire) mem[wrPtr] <= wrData;
  end

  // Synchronous read port, holds between accepted reads
  always_ff @(posedge clk or posedge rst) begin
    if (rst)                readStage <= '0;
    else if (strobe.rdFire) readStage <= mem[rdPtr];
  end

  generate
    if (OutReg) begin : gPipe
      logic [DataW-1:0] pipeStage;
      always_ff @(posedge clk or posedge rst) begin
        if (rst) pipeStage <= '0;
        else     pipeStage <= readStage;
      end
      assign rdData = pipeStage;
    end else begin : gDirect
      assign rdData = readStage;
    end
  endgenerate

endmodule

// File: rtl/sfifo_prog.sv
`timescale 1ns/1ps
module sfifo_prog
  import sfifo_pkg::*;
#(
  parameter int unsigned DataWidth         = 36,
  parameter bit          BigCapacity       = 1'b0,
  parameter int unsigned AlmostEmptyOffset = 128,
  parameter int unsigned AlmostFullOffset  = 128,
  parameter bit          OutputReg         = 1'b0,
  localparam int unsigned Depth            = depthFor(DataWidth, BigCapacity),
  localparam int unsigned CntW             = $clog2(Depth)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DataWidth-1:0] wrData,
  input  logic                 wrEn,
  input  logic                 rdEn,
  output logic [DataWidth-1:0] rdData,
  output logic                 full,
  output logic                 empty,
  output logic                 almostFull,
  output logic                 almostEmpty,
  output logic                 wrErr,
  output logic                 rdErr,
  output logic [CntW-1:0]      rdCount,
  output logic [CntW-1:0]      wrCount
);

  memStrobe_t strobe;

  sfifo_ctrl #(
    .Depth   (Depth),
    .CntW    (CntW),
    .AeOffset(AlmostEmptyOffset),
    .AfOffset(AlmostFullOffset)
  ) uCtrl (
    .clk        (clk),
    .rst        (rst),
    .wrEn       (wrEn),
    .rdEn       (rdEn),
    .strobe     (strobe),
    .wrPtr      (wrCount),
    .rdPtr      (rdCount),
    .full       (full),
    .empty      (empty),
    .almostFull (almostFull),
    .almostEmpty(almostEmpty),
    .wrErr      (wrErr),
    .rdErr      (rdErr)
  );

  sfifo_datapath #(
    .DataW (DataWidth),
    .Depth (Depth),
    .CntW  (CntW),
    .OutReg(OutputReg)
  ) uData (
    .clk   (clk),
    .rst   (rst),
    .strobe(strobe),
    .wrPtr (wrCount),
    .rdPtr (rdCount),
    .wrData(wrData),
    .rdData(rdData)
  );

endmodule

// File: rtl/sfifo_checker.sv
`timescale 1ns/1ps
module sfifo_checker #(
  parameter int unsigned CntW = 9
) (
  input logic            clk,
  input logic            rst,
  input logic            wrEn,
  input logic            rdEn,
  input logic            full,
  input logic            empty,
  input logic            almostFull,
  input logic            almostEmpty,
  input logic            wrErr,
  input logic            rdErr,
  input logic [CntW-1:0] rdCount,
  input logic [CntW-1:0] wrCount
);

  assert_full_empty_excl_R2: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  assert_ae_covers_empty_R5: assert property (@(posedge clk) disable iff (rst)
    empty |-> almostEmpty);

  assert_af_covers_full_R6: assert property (@(posedge clk) disable iff (rst)
    full |-> almostFull);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (full && wrEn) |=> ($stable(wrCount) && wrErr));

  assert_wr_err_cause_R7: assert property (@(posedge clk) disable iff (rst)
    wrErr |-> $past(full && wrEn));

  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
    (empty && rdEn) |=> ($stable(rdCount) && rdErr));

  assert_rd_err_cause_R8: assert property (@(posedge clk) disable iff (rst)
    rdErr |-> $past(empty && rdEn));

  assert_empty_both_R9: assert property (@(posedge clk) disable iff (rst)
    (empty && wrEn && rdEn) |=> (!empty && $stable(rdCount)));

endmodule

bind sfifo_prog sfifo_checker #(.CntW(CntW)) uChecker (
  .clk        (clk),
  .rst        (rst),
  .wrEn       (wrEn),
  .rdEn       (rdEn),
  .full       (full),
  .empty      (empty),
  .almostFull (almostFull),
  .almostEmpty(almostEmpty),
  .wrErr      (wrErr),
  .rdErr      (rdErr),
  .rdCount    (rdCount),
  .wrCount    (wrCount)
);

// File: tb/sim_sfifo_prog.sv
`timescale 1ns/1ps
module sim_sfifo_prog;

  localparam int DW    = 36;
  localparam int DEPTH = 512;   // R2: 36-bit word, small capacity
  localparam int CW    = 9;
  localparam int AE    = 128;
  localparam int AFLVL = DEPTH - 128;

  logic          clk = 1'b0;
  logic          rst;
  logic [DW-1:0] wrData;
  logic          wrEn, rdEn;
  logic [DW-1:0] rdData0, rdData1;
  logic          full0, empty0, af0, ae0, we0, re0;
  logic          full1, empty1, af1, ae1, we1, re1;
  logic [CW-1:0] rc0, wc0, rc1, wc1;

  int checks = 0;
  int fails  = 0;

  // reference model
  logic [DW-1:0] q[$];
  int            mOcc, mWp, mRp;
  logic [DW-1:0] s0, d1;
  logic          eWErr, eRErr;
  logic [DW-1:0] tagData = '0;

  always #2 clk = ~clk;

  sfifo_prog u0 (
    .clk(clk), .rst(rst), .wrData(wrData), .wrEn(wrEn), .rdEn(rdEn),
    .rdData(rdData0), .full(full0), .empty(empty0), .almostFull(af0),
    .almostEmpty(ae0), .wrErr(we0), .rdErr(re0), .rdCount(rc0), .wrCount(wc0)
  );

  sfifo_prog #(.OutputReg(1'b1)) u1 (
    .clk(clk), .rst(rst), .wrData(wrData), .wrEn(wrEn), .rdEn(rdEn),
    .rdData(rdData1), .full(full1), .empty(empty1), .almostFull(af1),
    .almostEmpty(ae1), .wrErr(we1), .rdErr(re1), .rdCount(rc1), .wrCount(wc1)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic modelReset();
    q.delete();
    mOcc = 0; mWp = 0; mRp = 0;
    s0 = '0; d1 = '0; eWErr = 1'b0; eRErr = 1'b0;
  endtask

  task automatic cmpAll();
    chk("R3",  "u0 rdData", 64'(rdData0), 64'(s0));
    chk("R4",  "u1 rdData", 64'(rdData1), 64'(d1));
    chk("R2",  "full",   {63'd0, full0},  {63'd0, mOcc == DEPTH});
    chk("R2",  "empty",  {63'd0, empty0}, {63'd0, mOcc == 0});
    chk("R5",  "almostEmpty", {63'd0, ae0}, {63'd0, mOcc <= AE});
    chk("R6",  "almostFull",  {63'd0, af0}, {63'd0, mOcc >= AFLVL});
    chk("R7",  "wrErr",  {63'd0, we0}, {63'd0, eWErr});
    chk("R8",  "rdErr",  {63'd0, re0}, {63'd0, eRErr});
    chk("R10", "wrCount", 64'(wc0), 64'(mWp));
    chk("R10", "rdCount", 64'(rc0), 64'(mRp));
    chk("R4",  "u1 flags", {58'd0, full1, empty1, af1, ae1, we1, re1},
                           {58'd0, full0, empty0, af0, ae0, we0, re0});
    chk("R4",  "u1 counts", {46'd0, wc1, rc1}, {46'd0, wc0, rc0});
  endtask

  // one clock: drive at negedge, update model, compare at next negedge
  task automatic step(input logic we, input logic re);
    logic wa, ra;
    tagData = tagData + 36'h1_0000_0007;
    wrEn = we; rdEn = re; wrData = tagData;
    eWErr = we && (mOcc == DEPTH);
    eRErr = re && (mOcc == 0);
    wa = we && (mOcc < DEPTH);
    ra = re && (mOcc > 0);
    d1 = s0;
    if (ra) s0 = q.pop_front();
    if (wa) q.push_back(tagData);
    mOcc = mOcc + int'(wa) - int'(ra);
    if (wa) mWp = (mWp + 1) % DEPTH;
    if (ra) mRp = (mRp + 1) % DEPTH;
    @(posedge clk);
    @(negedge clk);
    cmpAll();
  endtask

  task automatic tResetState();  // R1
    chk("R1", "empty",  {63'd0, empty0}, 64'd1);
    chk("R1", "flags",  {60'd0, full0, af0, we0, re0}, 64'd0);
    chk("R1", "counts", {46'd0, wc0, rc0}, 64'd0);
    chk("R1", "rdData", 64'(rdData0) | 64'(rdData1), 64'd0);
  endtask

  task automatic tFillOverflow();  // R2 R6 R7
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0);
    chk("R2", "full after depth writes", {63'd0, full0}, 64'd1);
    step(1'b1, 1'b0);
    chk("R7", "wrErr pulse", {63'd0, we0}, 64'd1);
    chk("R7", "wrCount held", 64'(wc0), 64'd0);
    step(1'b0, 1'b0);
    chk("R7", "wrErr one cycle", {63'd0, we0}, 64'd0);
  endtask

  task automatic tBothAtFull();  // R9
    step(1'b1, 1'b1);
    chk("R9", "read taken at full", {63'd0, full0}, 64'd0);
    chk("R9", "write refused at full", {63'd0, we0}, 64'd1);
    step(1'b1, 1'b0);
  endtask

  task automatic tDrainUnderflow();  // R3 R5 R8
    while (mOcc > 0) step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    chk("R8", "rdErr pulse", {63'd0, re0}, 64'd1);
    step(1'b0, 1'b0);
    chk("R8", "rdErr one cycle", {63'd0, re0}, 64'd0);
  endtask

  task automatic tBothAtEmpty();  // R9
    logic [CW-1:0] rcBefore;
    rcBefore = rc0;
    step(1'b1, 1'b1);
    chk("R9", "write taken at empty", {63'd0, empty0}, 64'd0);
    chk("R9", "read refused at empty", 64'(rc0), 64'(rcBefore));
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
  endtask

  task automatic tBothMiddle();  // R9
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0);
    for (int i = 0; i < 10; i++) begin
      step(1'b1, 1'b1);
      chk("R9", "occupancy steady", {63'd0, empty0 | full0}, 64'd0);
    end
    while (mOcc > 0) step(1'b0, 1'b1);
  endtask

  task automatic tRandom();  // R3 R4 R5 R6 R10
    for (int i = 0; i < 3000; i++) step(($urandom % 100) < 70, ($urandom % 100) < 40);
    for (int i = 0; i < 3000; i++) step(($urandom % 100) < 40, ($urandom % 100) < 70);
  endtask

  task automatic tAsyncReset();  // R1
    for (int i = 0; i < 40; i++) step(1'b1, i[0]);
    #1 rst = 1'b1;
    #0.5;
    modelReset();
    chk("R1", "async empty",  {63'd0, empty0}, 64'd1);
    chk("R1", "async counts", {46'd0, wc0, rc0}, 64'd0);
    chk("R1", "async rdData", 64'(rdData0) | 64'(rdData1), 64'd0);
    wrEn = 1'b0; rdEn = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    step(1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; wrEn = 1'b0; rdEn = 1'b0; wrData = '0;
    modelReset();
    repeat (3) @(negedge clk);
    tResetState();
    rst = 1'b0;
    step(1'b0, 1'b0);
    tFillOverflow();
    tBothAtFull();
    tDrainUnderflow();
    tBothAtEmpty();
    tBothMiddle();
    tRandom();
    tAsyncReset();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule